// File: doc/BRIEF.md
# Byte Permute Unit

This block assembles a 64-bit result from any eight of the sixteen bytes held in two 64-bit operands. The choice of bytes comes from a control word: its upper 32 bits hold eight 4-bit indices, one per output byte. The two operands form one 16-byte pool in big-endian order, so index values 0 to 7 reach into operand A and 8 to 15 reach into operand B. Permutes, reversals, byte extraction across an operand boundary and byte replication are all expressed by choosing the index pattern.

The datapath is purely combinational up to a single output register. A request is offered with `in_valid`, and the result appears with `out_valid` on the next cycle. Something else loads the control word; this block only reads it.

Top module: `byte_permute_unit`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `out_valid` and `out_data` become 0 at that edge.
- R2: Only `ctrl_word[63:32]` steers selection; bits [31:0] of the control word have no effect on `out_data`.
- R3: Output byte i (i = 0 is the most significant byte, `out_data[63-8i:56-8i]`) is steered by the index in `ctrl_word[63-4i:60-4i]`.
- R4: Index value k in 0..7 picks operand A byte `opa[63-8k:56-8k]` (k = 0 is the most significant byte of A).
- R5: Index value k in 8..15 picks operand B byte `opb[63-8(k-8):56-8(k-8)]` (k = 15 is the least significant byte of B).
- R6: Any index pattern is legal, including the same index in several positions; each such output byte carries a copy of the same source byte.
- R7: `out_valid` is high in the cycle after each cycle with `in_valid` high and low after each cycle with `in_valid` low.
- R8: When `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_word | input | 64 | Control word; upper half holds the eight byte indices |
| opa | input | 64 | Operand A, bytes 0..7 of the pool |
| opb | input | 64 | Operand B, bytes 8..15 of the pool |
| in_valid | input | 1 | Request strobe; result register loads when high |
| out_data | output | 64 | Registered permuted word |
| out_valid | output | 1 | High one cycle after an accepted request |

## Verification
Two functions meet in one cycle when a new request is loaded while the previous result is still on the output: back-to-back strobes make the register replace a valid result with the next, whereas gaps make it hold. The bench mixes runs of consecutive requests with idle gaps and checks every presented result in order against a queue of expected words, and checks during idle cycles that the last word stays unchanged. Index patterns cover identity, full reversal, all indices in one operand, repeated indices, and random patterns with random lower control bits.

// File: rtl/bpu_pkg.sv
// Package: shared geometry of the byte permute unit.
// Assumes 8-bit bytes and two source operands of equal width.
package bpu_pkg;
    localparam int BPU_DATA_W = 64;
    localparam int BPU_BYTE_W = 8;
    localparam int BPU_CTRL_W = 64;
    localparam int BPU_LANES  = BPU_DATA_W / BPU_BYTE_W;
    localparam int BPU_SEL_W  = $clog2(2 * BPU_LANES);
    localparam int BPU_MASK_W = BPU_LANES * BPU_SEL_W;
endpackage

// File: rtl/bpu_sel_split.sv
// Module: slices the mask field at the top of the control word into
// one index per output lane. Lane 0 takes the most significant index.
// Assumes CTRL_W >= LANES*SEL_W.
module bpu_sel_split #(
    parameter int CTRL_W = 64,
    parameter int LANES  = 8,
    parameter int SEL_W  = 4
) (
    input  logic [CTRL_W-1:0]           ctrl_word,
    output logic [LANES-1:0][SEL_W-1:0] lane_sel
);
    localparam int MASK_W = LANES * SEL_W;

    logic [MASK_W-1:0] mask;

    assign mask = ctrl_word[CTRL_W-1 -: MASK_W];

    // Cut the mask into per-lane indices, most significant first.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_sel[i] = mask[MASK_W-1-SEL_W*i -: SEL_W];
        end
    end
endmodule

// File: rtl/bpu_lane_mux.sv
// Module: picks one byte from the big-endian byte pool by index.
// Pool byte 0 is the most significant byte of the pool vector.
// Assumes the pool holds exactly 2**SEL_W bytes.
module bpu_lane_mux #(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic [(2**SEL_W)*BYTE_W-1:0] pool,
    input  logic [SEL_W-1:0]             sel,
    output logic [BYTE_W-1:0]            picked
);
    localparam int POOL_BYTES = 2 ** SEL_W;

    // One-hot style scan so each candidate byte is a plain AND-OR term.
    always_comb begin
        picked = '0;
        for (int k = 0; k < POOL_BYTES; k++) begin
            if (sel == SEL_W'(k)) begin
                picked = pool[(POOL_BYTES-1-k)*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/bpu_out_reg.sv
// Module: result register with a valid flag. Loads data on load_en,
// otherwise holds; valid mirrors load_en one cycle later.
// Assumes a synchronous active-low reset.
module bpu_out_reg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              q_valid
);
    // Capture the permuted word only when a request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= d;
        end
    end

    // Flag a fresh result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= load_en;
        end
    end
endmodule

// File: rtl/byte_permute_unit.sv
// Module: top of the byte permute unit. Builds a word from eight bytes
// chosen out of {opa, opb} by indices in ctrl_word's upper half, and
// registers it. Assumes the control word is stable with in_valid.
module byte_permute_unit #(
    parameter int DATA_W = bpu_pkg::BPU_DATA_W,
    parameter int BYTE_W = bpu_pkg::BPU_BYTE_W,
    parameter int CTRL_W = bpu_pkg::BPU_CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              in_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    localparam int LANES = DATA_W / BYTE_W;
    localparam int SEL_W = $clog2(2 * LANES);

    logic [LANES-1:0][SEL_W-1:0] lane_sel;
    logic [2*DATA_W-1:0]         pool;
    logic [DATA_W-1:0]           permuted;

    // Operand A occupies the upper (lower-indexed) half of the pool.
    assign pool = {opa, opb};

    bpu_sel_split #(
        .CTRL_W (CTRL_W),
        .LANES  (LANES),
        .SEL_W  (SEL_W)
    ) u_split (
        .ctrl_word (ctrl_word),
        .lane_sel  (lane_sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bpu_lane_mux #(
            .BYTE_W (BYTE_W),
            .SEL_W  (SEL_W)
        ) u_mux (
            .pool   (pool),
            .sel    (lane_sel[i]),
            .picked (permuted[DATA_W-1-BYTE_W*i -: BYTE_W])
        );
    end

    bpu_out_reg #(
        .DATA_W (DATA_W)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (in_valid),
        .d       (permuted),
        .q       (out_data),
        .q_valid (out_valid)
    );
endmodule

// File: rtl/bpu_checker.sv
// Module: temporal checks on the byte permute unit's ports, bound to
// every instance of the top module.
module bpu_checker #(
    parameter int DATA_W = 64,
    parameter int CTRL_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic              in_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));

    p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

    p_top_from_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_word[CTRL_W-1 -: 4] == 4'd0)
        |=> out_data[DATA_W-1 -: 8] == $past(opa[DATA_W-1 -: 8]));

    p_low_from_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl_word[CTRL_W-29 -: 4] == 4'd15)
        |=> out_data[7:0] == $past(opb[7:0]));
endmodule

bind byte_permute_unit bpu_checker #(
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
) u_bpu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .opa       (opa),
    .opb       (opb),
    .in_valid  (in_valid),
    .out_data  (out_data),
    .out_valid (out_valid)
);

// File: tb/tb_byte_permute_unit.sv
// Scoreboard bench: the driver queues expected words, the monitor
// compares them as results appear.
module tb_byte_permute_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ctrl_word = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        in_valid = 1'b0;
    logic [63:0] out_data;
    logic        out_valid;

    int total = 0;
    int bad = 0;
    logic [63:0] q_exp[$];
    string       q_tag[$];
    logic [63:0] last_word = '0;
    logic        mon_on = 1'b0;
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    byte_permute_unit dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .opa(opa), .opb(opb),
        .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid)
    );

    function automatic logic [63:0] model(input logic [63:0] c,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [127:0] p;
        logic [63:0]  r;
        p = {a, b};
        for (int i = 0; i < 8; i++) begin
            int k;
            k = int'(c[63-4*i -: 4]);
            r[63-8*i -: 8] = p[127-8*k -: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input string tag, input logic [63:0] c,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        ctrl_word = c; opa = a; opb = b; in_valid = 1'b1;
        q_exp.push_back(model(c, a, b));
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            in_valid = 1'b0;
            ctrl_word = {$urandom, $urandom};
            opa = {$urandom, $urandom};
            opb = {$urandom, $urandom};
        end
    endtask

    // Monitor: compare presented results, and idle holding, after each edge.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check("R7 unexpected valid", 64'd1, 64'd0);
                end else begin
                    check(q_tag.pop_front(), out_data, q_exp.pop_front());
                    last_word = out_data;
                end
            end else begin
                check("R8 hold while idle", out_data, last_word);
            end
        end
    end

    initial begin
        logic [63:0] a, b, c;
        a = 64'h0011_2233_4455_6677;
        b = 64'h8899_AABB_CCDD_EEFF;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        drive("R4 identity from A", 64'h0123_4567_0000_0000, a, b);
        drive("R5 identity from B", 64'h89AB_CDEF_0000_0000, a, b);
        drive("R3 reversal", 64'hFEDC_BA98_0000_0000, a, b);
        idle(2);
        drive("R6 replicate index 0", 64'h0000_0000_0000_0000, a, b);
        drive("R6 replicate index 15", 64'hFFFF_FFFF_1234_5678, a, b);
        idle(1);
        drive("R3 straddle boundary", 64'h4567_89AB_0000_0000, a, b);
        drive("R2 low bits set", 64'h3B1F_0E8C_FFFF_FFFF, a, b);
        drive("R2 low bits clear", 64'h3B1F_0E8C_0000_0000, a, b);
        idle(3);
        for (int n = 0; n < 40; n++) begin
            c = {$urandom, $urandom};
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            drive("R3 random pattern", c, a, b);
            if (n % 5 == 4) idle(n % 3 + 1);
        end
        idle(3);
        check("R7 all results seen", 64'(q_exp.size()), 64'd0);

        @(negedge clk);
        rst_n = 1'b0;
        mon_on = 1'b0;
        drive("R1 dropped", 64'h0123_4567_0000_0000, a, b);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 reset mid-run valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset mid-run data", out_data, 64'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule